// File: doc/BRIEF.md
# Interrupt vector ring writer

The block accepts interrupt events from on-chip sources, one per handshake, and packs each into a 128-bit vector that it stores in a circular ring held in an internal memory. A host reads stored vectors through a separate memory read port. It also sees a level interrupt whenever unread entries are pending. The ring is 16-byte aligned, and both pointers count bytes.

The host programs the ring through four 32-bit registers selected by a 2-bit address:
- 0: control
- 1: read pointer, written by the host
- 2: write pointer readback, with a sticky overflow flag in bit 31
- 3: a mirrored copy of the write pointer readback, which stands in for a memory writeback

The control register bits are:
- bit 0: ring enable
- bits [5:1]: ring size, as log2 of the ring length in 32-bit words
- bit 6: interrupt enable
- bit 7: overflow enable
- bit 8: overflow clear
- bit 9: mirror enable
- bit 10: rearm

With overflow enabled, a full ring keeps taking vectors and overwrites the oldest ones. With overflow disabled, a full ring holds off the source.

Top module: `irq_vec_ring`

## Requirements
- R1: Each stored vector is laid out as follows, with every other bit zero:
  - bits [7:0]: source id
  - bits [59:32]: 28-bit source data
  - bits [71:64]: ring id
  - bits [79:72]: VM id
  - bits [95:80]: 16-bit address-space id
- R2: Each accepted vector is stored at entry index wptr/16 and advances the write pointer by 16, modulo the ring byte size. Both pointers always stay 16-byte aligned.
- R3: Control bits [5:1] hold the ring size as log2 of words. The ring byte size is 4<<size. A value below 3 acts as 3, and a value above MAX_LOG2_WORDS acts as MAX_LOG2_WORDS.
- R4: irq_pending is high exactly when interrupt enable is set and either the pointers differ or the overflow flag is set.
- R5: When ring enable or interrupt enable is clear, ev_ready stays high and events are dropped. In that case the write pointer and the ring contents do not change.
- R6: With overflow disabled, a full ring drives ev_ready low, stores nothing and never sets the overflow flag. The ring is full when wptr+16 modulo the ring size equals rptr.
- R7: With overflow enabled, a vector arriving on a full ring is still stored and sets the overflow flag, which reads back in bit 31 of register 2. Afterwards the oldest of the last N-1 vectors sits at (wptr+16) modulo the ring size.
- R8: The overflow flag is sticky. It reads zero while control bit 8 is set, and once that bit is cleared a new overflow sets the flag again.
- R9: Writing control with bit 0 clear also clears interrupt enable and resets both pointers and the overflow flag to zero.
- R10: While mirror enable is set, register 3 equals register 2. While it is clear, register 3 holds its last value.
- R11: With rearm and interrupt enable set, a host write of the read pointer that leaves it unequal to the write pointer raises irq_retrig for exactly the following cycle.
- R12: A host write of the read pointer is masked to the ring byte size, and its low 4 bits are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken (or dropped) this cycle |
| ev_src_id | input | 8 | Source id |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring id |
| ev_vm_id | input | 8 | VM id |
| ev_pasid | input | 16 | Address-space id |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data (combinational) |
| mem_rd_idx | input | MAX_LOG2_WORDS-2 | Ring entry to read |
| mem_rd_data | output | 128 | Stored vector at mem_rd_idx |
| irq_pending | output | 1 | Unread entries or overflow pending |
| irq_retrig | output | 1 | One-cycle re-trigger after read-pointer write |

## Verification
Every ring size from two to sixteen entries is tried with the same sequence of patterns:
- Partial fill, then one extra offer against the full ring with overflow off. This separates the stall from a silent overwrite.
- A walk that reads each vector as it is written, so that both pointers cross the wrap point. This separates a correct modulo from an off-by-one mask.
- A burst longer than the ring with overflow on. This exposes both the flag and the placement of the oldest survivor.

Clear-then-refill, mirror freeze, rearm writes and disable/drop sequences each isolate a single control bit. Out-of-range size codes confirm the clamping at both ends.

// File: rtl/irq_ring_pkg.sv
`timescale 1ns/1ps
package irq_ring_pkg;

    localparam int unsigned VEC_W          = 128;
    localparam int unsigned ENTRY_SHIFT    = 4;   // 16 bytes per vector
    localparam int unsigned MIN_LOG2_WORDS = 3;   // two entries

    // control register bit positions
    localparam int unsigned CB_RING_EN  = 0;
    localparam int unsigned CB_SIZE_LO  = 1;
    localparam int unsigned CB_SIZE_W   = 5;
    localparam int unsigned CB_INT_EN   = 6;
    localparam int unsigned CB_OVF_EN   = 7;
    localparam int unsigned CB_OVF_CLR  = 8;
    localparam int unsigned CB_WB_EN    = 9;
    localparam int unsigned CB_REARM    = 10;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RPTR   = 2'd1,
        SEL_WPTR   = 2'd2,
        SEL_MIRROR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vm_id;
        logic [15:0] pasid;
    } irq_event_t;

    function automatic logic [CB_SIZE_W-1:0] clamp_log2(
        input logic [CB_SIZE_W-1:0] req,
        input logic [CB_SIZE_W-1:0] lo,
        input logic [CB_SIZE_W-1:0] hi
    );
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/irq_vec_pack.sv
`timescale 1ns/1ps
module irq_vec_pack
    import irq_ring_pkg::*;
(
    input  irq_event_t        ev,
    output logic [VEC_W-1:0]  vec
);
    // assemble the vector field by field; every unnamed bit is zero
    always_comb begin
        vec          = '0;
        vec[7:0]     = ev.src_id;
        vec[59:32]   = ev.src_data;
        vec[71:64]   = ev.ring_id;
        vec[79:72]   = ev.vm_id;
        vec[95:80]   = ev.pasid;
    end
endmodule

// File: rtl/irq_ring_store.sv
`timescale 1ns/1ps
module irq_ring_store #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned DAT_W = 128,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DAT_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DAT_W-1:0]  rd_data
);
    logic [DAT_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cell_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_idx];
endmodule

// File: rtl/irq_ring_ctrl.sv
`timescale 1ns/1ps
module irq_ring_ctrl
    import irq_ring_pkg::*;
#(
    parameter int unsigned MAX_LOG2_WORDS = 6,
    localparam int unsigned PTR_W = MAX_LOG2_WORDS + 2,
    localparam int unsigned IDX_W = MAX_LOG2_WORDS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq_pending,
    output logic              irq_retrig
);
    localparam logic [PTR_W-1:0] STEP      = PTR_W'(1 << ENTRY_SHIFT);
    localparam logic [PTR_W-1:0] ALIGN_MSK = ~PTR_W'((1 << ENTRY_SHIFT) - 1);
    localparam int unsigned      PAD_W     = 31 - PTR_W;

    typedef struct packed {
        logic                 ring_en;
        logic                 int_en;
        logic                 ovf_en;
        logic                 ovf_clr;
        logic                 wb_en;
        logic                 rearm;
        logic [CB_SIZE_W-1:0] size;
        logic [PTR_W-1:0]     wptr;
        logic [PTR_W-1:0]     rptr;
        logic                 ovf;
        logic [31:0]          mirror;
        logic                 retrig;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [CB_SIZE_W-1:0] size_eff;
    logic [PTR_W-1:0]     ptr_mask;
    logic [PTR_W-1:0]     wptr_next;
    logic                 ring_full;
    logic                 active;
    logic                 accept;
    logic [31:0]          rdbk_q;
    logic [31:0]          rdbk_d;
    logic [PTR_W-1:0]     rptr_wr;
    logic                 ctrl_wr;
    logic                 rptr_wr_en;
    logic [20:0]          unused_hi;

    assign unused_hi  = host_wdata[31:11];
    assign ctrl_wr    = host_wr && (host_addr == SEL_CTRL);
    assign rptr_wr_en = host_wr && (host_addr == SEL_RPTR);

    always_comb begin
        size_eff  = clamp_log2(st_q.size, CB_SIZE_W'(MIN_LOG2_WORDS),
                               CB_SIZE_W'(MAX_LOG2_WORDS));
        ptr_mask  = PTR_W'((32'd4 << size_eff) - 32'd1);
        wptr_next = (st_q.wptr + STEP) & ptr_mask;
        ring_full = (wptr_next == st_q.rptr);
        active    = st_q.ring_en && st_q.int_en;
        ev_ready  = !active || st_q.ovf_en || !ring_full;
        accept    = ev_valid && active && (st_q.ovf_en || !ring_full);
        rptr_wr   = host_wdata[PTR_W-1:0] & ptr_mask & ALIGN_MSK;

        st_d        = st_q;
        st_d.retrig = 1'b0;

        if (accept) begin
            st_d.wptr = wptr_next;
            if (ring_full) begin
                st_d.ovf = 1'b1;
            end
        end

        if (ctrl_wr) begin
            st_d.ring_en = host_wdata[CB_RING_EN];
            st_d.size    = host_wdata[CB_SIZE_LO +: CB_SIZE_W];
            st_d.int_en  = host_wdata[CB_INT_EN];
            st_d.ovf_en  = host_wdata[CB_OVF_EN];
            st_d.ovf_clr = host_wdata[CB_OVF_CLR];
            st_d.wb_en   = host_wdata[CB_WB_EN];
            st_d.rearm   = host_wdata[CB_REARM];
            if (!host_wdata[CB_RING_EN]) begin
                st_d.int_en = 1'b0;
                st_d.wptr   = '0;
                st_d.rptr   = '0;
                st_d.ovf    = 1'b0;
            end
        end

        if (rptr_wr_en) begin
            st_d.rptr = rptr_wr;
            if (st_q.rearm && st_q.int_en && (rptr_wr != st_d.wptr)) begin
                st_d.retrig = 1'b1;
            end
        end

        if (st_d.ovf_clr) begin
            st_d.ovf = 1'b0;
        end

        rdbk_d = {st_d.ovf, {PAD_W{1'b0}}, st_d.wptr};
        if (st_d.wb_en) begin
            st_d.mirror = rdbk_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdbk_q      = {st_q.ovf, {PAD_W{1'b0}}, st_q.wptr};
    assign wr_en       = accept;
    assign wr_idx      = st_q.wptr[PTR_W-1:ENTRY_SHIFT];
    assign irq_pending = st_q.int_en && ((st_q.wptr != st_q.rptr) || st_q.ovf);
    assign irq_retrig  = st_q.retrig;

    always_comb begin
        unique case (host_addr)
            SEL_CTRL:   host_rdata = {21'd0, st_q.rearm, st_q.wb_en, st_q.ovf_clr,
                                      st_q.ovf_en, st_q.int_en, st_q.size, st_q.ring_en};
            SEL_RPTR:   host_rdata = 32'(st_q.rptr);
            SEL_WPTR:   host_rdata = rdbk_q;
            default:    host_rdata = st_q.mirror;
        endcase
    end

    // ---------------- assertions ----------------
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wptr[ENTRY_SHIFT-1:0] == '0) && (st_q.rptr[ENTRY_SHIFT-1:0] == '0)); // R2

    AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (size_eff >= CB_SIZE_W'(MIN_LOG2_WORDS)) && (size_eff <= CB_SIZE_W'(MAX_LOG2_WORDS))); // R3

    AST_DROP_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_q.ring_en && st_q.int_en) && !ctrl_wr) |=> $stable(st_q.wptr)); // R5

    AST_NO_SILENT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ovf_en && !st_q.ovf && !ctrl_wr) |=> !st_q.ovf); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ctrl_wr) |=> st_q.ovf); // R8

    AST_CLR_MASKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf_clr |-> !st_q.ovf); // R8

    AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !host_wdata[CB_RING_EN]) |=>
        ((st_q.wptr == '0) && (st_q.rptr == '0) && !st_q.ovf && !st_q.int_en)); // R9

    AST_MIRROR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wb_en |-> (st_q.mirror == rdbk_q)); // R10

    AST_RETRIG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_retrig) |-> $past(rptr_wr_en)); // R11

endmodule

// File: rtl/irq_vec_ring.sv
`timescale 1ns/1ps
module irq_vec_ring
    import irq_ring_pkg::*;
#(
    parameter int unsigned MAX_LOG2_WORDS = 6,
    localparam int unsigned IDX_W = MAX_LOG2_WORDS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_src_id,
    input  logic [27:0]       ev_src_data,
    input  logic [7:0]        ev_ring_id,
    input  logic [7:0]        ev_vm_id,
    input  logic [15:0]       ev_pasid,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [IDX_W-1:0]  mem_rd_idx,
    output logic [VEC_W-1:0]  mem_rd_data,
    output logic              irq_pending,
    output logic              irq_retrig
);
    irq_event_t          ev;
    logic [VEC_W-1:0]    vec;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;

    assign ev = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                  vm_id: ev_vm_id, pasid: ev_pasid};

    irq_vec_pack i_pack (
        .ev  (ev),
        .vec (vec)
    );

    irq_ring_ctrl #(
        .MAX_LOG2_WORDS (MAX_LOG2_WORDS)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_ready    (ev_ready),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .irq_pending (irq_pending),
        .irq_retrig  (irq_retrig)
    );

    irq_ring_store #(
        .IDX_W (IDX_W),
        .DAT_W (VEC_W)
    ) i_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (vec),
        .rd_idx  (mem_rd_idx),
        .rd_data (mem_rd_data)
    );
endmodule

// File: tb/test_irq_vec_ring.sv
`timescale 1ns/1ps
module test_irq_vec_ring;
    localparam int MAXL  = 6;
    localparam int IDX_W = MAXL - 2;
    localparam int DEPTH = 1 << IDX_W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_valid = 1'b0;
    logic         ev_ready;
    logic [7:0]   ev_src_id = '0;
    logic [27:0]  ev_src_data = '0;
    logic [7:0]   ev_ring_id = '0;
    logic [7:0]   ev_vm_id = '0;
    logic [15:0]  ev_pasid = '0;
    logic         host_wr = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic [IDX_W-1:0] mem_rd_idx = '0;
    logic [127:0] mem_rd_data;
    logic         irq_pending;
    logic         irq_retrig;

    irq_vec_ring #(.MAX_LOG2_WORDS(MAXL)) i_irq_vec_ring (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
        .ev_vm_id(ev_vm_id), .ev_pasid(ev_pasid), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .irq_pending(irq_pending), .irq_retrig(irq_retrig)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model
    logic [127:0] m_mem [DEPTH];
    bit           m_vld [DEPTH];
    int           m_w, m_r, m_mask, evn;
    bit           m_ovf;

    function automatic logic [127:0] exp_vec(int k);
        return {32'h0, 16'(k * 771 + 9), 8'(k + 100), 8'(k ^ 32'h5a), 4'h0,
                28'(k * 12345 + 3), 24'h0, 8'(k * 37 + 5)};
    endfunction

    function automatic logic [31:0] ctl(bit en, int sz, bit ie, bit oe, bit clr, bit wb, bit ra);
        return {21'd0, ra, wb, clr, oe, ie, 5'(sz), en};
    endfunction

    function automatic int clampsz(int s);
        if (s < 3) return 3;
        if (s > MAXL) return MAXL;
        return s;
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 2'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        host_addr = 2'(a);
        #0.5;
        v = host_rdata;
    endtask

    task automatic drive_ev(int k);
        ev_src_id = 8'(k * 37 + 5);
        ev_src_data = 28'(k * 12345 + 3);
        ev_ring_id = 8'(k ^ 32'h5a);
        ev_vm_id = 8'(k + 100);
        ev_pasid = 16'(k * 771 + 9);
    endtask

    // offer one event for one clock; model it as stored
    task automatic push();
        int nxt;
        @(negedge clk);
        drive_ev(evn);
        ev_valid = 1'b1;
        #0.5;
        check(ev_ready === 1'b1, "R7", "ready on accept", 128'(ev_ready), 128'(1));
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        nxt = (m_w + 16) & m_mask;
        m_mem[m_w >> 4] = exp_vec(evn);
        m_vld[m_w >> 4] = 1'b1;
        if (nxt == m_r) m_ovf = 1'b1;
        m_w = nxt;
        evn++;
    endtask

    // offer one event that the design must drop
    task automatic offer_dropped();
        @(negedge clk);
        drive_ev(evn + 1000);
        ev_valid = 1'b1;
        #0.5;
        check(ev_ready === 1'b1, "R5", "ready while inactive", 128'(ev_ready), 128'(1));
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic check_wptr(string req);
        logic [31:0] v;
        rd(2, v);
        check(v == {m_ovf, 23'd0, 8'(m_w)}, req, "wptr readback", 128'(v), 128'({m_ovf, 23'd0, 8'(m_w)}));
    endtask

    task automatic check_mem(string req);
        for (int i = 0; i < DEPTH; i++) begin
            if (m_vld[i]) begin
                mem_rd_idx = IDX_W'(i);
                #0.1;
                check(mem_rd_data == m_mem[i], req, "ring entry", mem_rd_data, m_mem[i]);
            end
        end
    endtask

    task automatic check_pending(string req);
        bit e;
        e = (m_w != m_r) || m_ovf;
        #0.1;
        check(irq_pending == e, req, "irq_pending", 128'(irq_pending), 128'(e));
    endtask

    task automatic model_disable();
        m_w = 0; m_r = 0; m_ovf = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, keep;
        int n;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        evn = 0;
        model_disable();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        rd(2, v);
        check(v == 32'h0, "R9", "reset wptr", 128'(v), 128'(0));
        check(irq_pending == 1'b0, "R4", "reset pending", 128'(irq_pending), 128'(0));

        for (int s = 3; s <= MAXL; s++) begin
            n = 1 << (s - 2);
            m_mask = (4 << s) - 1;
            wr(0, ctl(0, s, 0, 0, 0, 1, 0));
            model_disable();
            wr(0, ctl(1, s, 1, 0, 0, 1, 0));
            check_wptr("R2");
            check_pending("R4");

            // fill to one short of the ring
            for (int j = 0; j < n - 1; j++) push();
            check_wptr("R2");
            check_pending("R4");
            check_mem("R1");

            // full ring, overflow off: stall
            @(negedge clk);
            drive_ev(evn + 500);
            ev_valid = 1'b1;
            #0.5;
            check(ev_ready == 1'b0, "R6", "ready on full", 128'(ev_ready), 128'(0));
            repeat (2) @(negedge clk);
            ev_valid = 1'b0;
            check_wptr("R6");
            check_mem("R6");

            // drain and walk across the wrap point
            wr(1, 32'(m_w)); m_r = m_w;
            check_pending("R4");
            for (int j = 0; j < n + 2; j++) begin
                push();
                check_wptr("R2");
                wr(1, 32'(m_w)); m_r = m_w;
            end
            check_mem("R2");

            // overflow on, burst past the ring
            wr(0, ctl(1, s, 1, 1, 0, 1, 0));
            for (int j = 0; j < n + 2; j++) push();
            check_wptr("R7");
            check(m_ovf == 1'b1, "R7", "model overflow expected", 128'(m_ovf), 128'(1));
            mem_rd_idx = IDX_W'(((m_w + 16) & m_mask) >> 4);
            #0.1;
            check(mem_rd_data == exp_vec(evn - (n - 1)), "R7", "oldest survivor",
                  mem_rd_data, exp_vec(evn - (n - 1)));
            check_mem("R7");
            rd(2, v); rd(3, keep);
            check(keep == v, "R10", "mirror tracks", 128'(keep), 128'(v));
            check_pending("R4");

            // clear, release, re-detect
            wr(0, ctl(1, s, 1, 1, 1, 1, 0)); m_ovf = 0;
            check_wptr("R8");
            wr(0, ctl(1, s, 1, 1, 0, 1, 0));
            check_wptr("R8");
            for (int j = 0; j < n; j++) push();
            rd(2, v);
            check(v[31] == 1'b1, "R8", "flag re-detected", 128'(v[31]), 128'(1));
            check_wptr("R8");

            // mirror freeze
            wr(0, ctl(1, s, 1, 1, 0, 0, 0));
            rd(3, keep);
            push();
            rd(3, v);
            check(v == keep, "R10", "mirror holds", 128'(v), 128'(keep));

            // rearm pulse
            wr(0, ctl(1, s, 1, 1, 0, 1, 1));
            wr(1, 32'((m_w + 16) & m_mask)); m_r = (m_w + 16) & m_mask;
            check(irq_retrig == 1'b1, "R11", "retrig pulse", 128'(irq_retrig), 128'(1));
            @(negedge clk);
            check(irq_retrig == 1'b0, "R11", "retrig one cycle", 128'(irq_retrig), 128'(0));
            wr(1, 32'(m_w)); m_r = m_w;
            check(irq_retrig == 1'b0, "R11", "no retrig when equal", 128'(irq_retrig), 128'(0));

            // disable
            wr(0, ctl(0, s, 1, 1, 0, 1, 0));
            model_disable();
            rd(0, v);
            check(v[6] == 1'b0, "R9", "int enable forced off", 128'(v[6]), 128'(0));
            rd(1, v);
            check(v == 32'h0, "R9", "rptr reset", 128'(v), 128'(0));
            check_wptr("R9");
            check_pending("R9");

            // drops while disabled and while interrupts off
            offer_dropped();
            check_wptr("R5");
            wr(0, ctl(1, s, 0, 0, 0, 1, 0));
            offer_dropped();
            check_wptr("R5");
            check_mem("R5");

            // rptr masking and alignment
            wr(1, 32'hFFFF_FFF7);
            rd(1, v);
            check(v == 32'(32'hFFF0 & m_mask), "R12", "rptr masked", 128'(v), 128'(32'hFFF0 & m_mask));
        end

        // clamping of the size field
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0));
        model_disable();
        wr(0, ctl(1, 1, 1, 1, 0, 0, 0));
        m_mask = (4 << clampsz(1)) - 1;
        push(); push();
        check_wptr("R3");
        wr(0, ctl(1, 31, 1, 1, 0, 0, 0));
        m_mask = (4 << clampsz(31)) - 1;
        wr(1, 32'h0000_0FFF);
        rd(1, v);
        check(v == 32'(32'hFF0 & m_mask), "R3", "large size clamps", 128'(v), 128'(32'hFF0 & m_mask));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule